// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Wake-Event Line Controller

This block watches 36 asynchronous request lines and turns chosen transitions on them into interrupt requests for a downstream interrupt controller, a one-cycle wake event pulse, and a level wake-up request for power management. Twenty-eight lines are external. Each external line can be set to trigger on its rising edge, its falling edge or both. It holds a sticky pending flag that software clears by writing 1, and software can also fire it. The other eight lines are internal. They react only to rising edges, keep no pending state, start unmasked, and are heard only while the chip is in stop mode.

Software reaches the controller through a word-wide register port that completes in one cycle. The port has two banks of six registers in the same order: interrupt mask, event mask, rising select, falling select, software trigger and pending. Bank 0 covers lines 0 to 31. Bank 1 covers lines 32 to 35 in bits 3:0. Every input passes through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one clock earlier.

Top module: `line_evt_ctrl`

## Requirements
- R1: A transition on `line_in` that is applied between two clock edges reaches `irq_req`, `evt_pulse` and the pending register after the third following rising clock edge, and not before.
- R2: An external line triggers on a rising edge when its rising-select bit is 1, and on a falling edge when its falling-select bit is 1. With both bits set, each edge triggers. An edge whose select bit is 0 does nothing.
- R3: A trigger on an external line whose interrupt mask bit is 1 sets that line's pending bit. The bit holds until software writes 1 to it at the pending offset. Writing 0 leaves it unchanged. If a trigger and a clearing write fall in the same cycle, the bit stays set.
- R4: For an external line, `irq_req[i]` equals pending AND interrupt mask. Clearing the mask bit drops the request but keeps the pending bit, and setting the mask again brings the request back.
- R5: Lines 23 to 28, 34 and 35 are internal. They respond only to a rising edge and only when `stop_mode` was 1 in the cycle the edge was detected. They then raise `irq_req[i]` for one cycle if their interrupt mask bit is 1. Their pending bits always read 0.
- R6: A trigger on a line whose event mask bit is 1 makes `evt_pulse` high for exactly one cycle. An event alone, with the interrupt mask bit at 0, sets no pending bit.
- R7: Writing 1 to an external line's software-trigger bit while that bit is 0 sets the bit. If the interrupt mask bit is 1, the same write also sets the pending bit in that cycle, and the result reads back on the next access. The software-trigger bit is cleared by the write-1 that clears the matching pending bit. When the mask bit is 0, no pending bit is set.
- R8: If a hardware edge on an external line is detected in the same cycle as a bus write to the rising-select or falling-select register of that line's bank, the pending bit is not set.
- R9: Register offsets are: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. Bank 1 uses the same order at 0x20 to 0x34. After reset, bank 0 interrupt mask reads 0x1F80_0000, bank 1 interrupt mask reads 0xFFFF_FFFC, and every other register reads 0.
- R10: In the rising-select, falling-select, software-trigger and pending registers, the bits of internal lines and the bits above line 35 read 0 and ignore writes. Offsets 0x18, 0x1C, 0x38 and 0x3C read 0 and ignore writes.
- R11: `wake_req` is 1 whenever any `irq_req` bit or `evt_pulse` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset; bit 5 picks the bank, bits 4:2 the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| line_in | input | 36 | Asynchronous request lines |
| stop_mode | input | 1 | High while the system is in stop mode |
| irq_req | output | 36 | Per-line interrupt request |
| evt_pulse | output | 1 | One-cycle wake event pulse |
| wake_req | output | 1 | Wake-up request to power management |

## Verification
The assertions assume that `stop_mode` and the bus signals are synchronous to `clk`. They also assume that a line changes level no more than once every three cycles, so each transition is seen by the edge detector as a single edge. The stimulus drives every input one time unit after a rising edge and holds each line level for at least three cycles before changing it again. Bus accesses are driven one at a time and never overlap. A same-cycle collision is created on purpose, only where R3 and R8 require it.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned NBANK  = 2;
  localparam int unsigned WIDE_W = REG_W * NBANK;

  typedef enum logic [2:0] {
    RSEL_IMASK = 3'd0,
    RSEL_EMASK = 3'd1,
    RSEL_RISE  = 3'd2,
    RSEL_FALL  = 3'd3,
    RSEL_SWTRG = 3'd4,
    RSEL_PEND  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned N      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg_q [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [N-1:0] stg_n;
      if (k == 0) begin : g_first
        assign stg_n = din;
      end else begin : g_next
        assign stg_n = stg_q[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[k] <= '0;
        else        stg_q[k] <= stg_n;
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
#(
  parameter int unsigned    N         = 36,
  parameter logic [N-1:0]   INT_LINES = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [N-1:0]      pend,
  output logic [N-1:0]      imr,
  output logic [N-1:0]      emr,
  output logic [N-1:0]      rtsr,
  output logic [N-1:0]      ftsr,
  output logic [N-1:0]      sw_trig,
  output logic [N-1:0]      pend_clr,
  output logic [N-1:0]      trig_wr_hit
);
  localparam logic [N-1:0] EXT = ~INT_LINES;

  logic [N-1:0] lane_hit, wbit;
  logic [N-1:0] imr_q, emr_q, rtsr_q, ftsr_q, swt_q;
  logic [N-1:0] imr_n, emr_n, rtsr_n, ftsr_n, swt_n, sw_set;
  logic         wr_en;
  logic [2:0]   rsel;

  assign wr_en = bus_sel & bus_wr;
  assign rsel  = bus_addr[4:2];

  // Map each line onto its bank lane and write-data bit
  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      assign lane_hit[i] = (bus_addr[5] == 1'(i / REG_W));
      assign wbit[i]     = bus_wdata[i % REG_W];
    end
  endgenerate

  function automatic logic [N-1:0] merge(input logic [N-1:0] cur, input logic hit,
                                         input logic [N-1:0] lanes, input logic [N-1:0] bits,
                                         input logic [N-1:0] keep);
    merge = hit ? (((cur & ~lanes) | (bits & lanes)) & keep) : cur;
  endfunction

  always_comb begin
    imr_n  = merge(imr_q,  wr_en && rsel == RSEL_IMASK, lane_hit, wbit, '1);
    emr_n  = merge(emr_q,  wr_en && rsel == RSEL_EMASK, lane_hit, wbit, '1);
    rtsr_n = merge(rtsr_q, wr_en && rsel == RSEL_RISE,  lane_hit, wbit, EXT);
    ftsr_n = merge(ftsr_q, wr_en && rsel == RSEL_FALL,  lane_hit, wbit, EXT);
    sw_set   = (wr_en && rsel == RSEL_SWTRG) ? (wbit & lane_hit & EXT) : '0;
    pend_clr = (wr_en && rsel == RSEL_PEND)  ? (wbit & lane_hit & EXT) : '0;
    trig_wr_hit = (wr_en && (rsel == RSEL_RISE || rsel == RSEL_FALL)) ? lane_hit : '0;
    sw_trig  = sw_set & ~swt_q;
    swt_n    = (swt_q & ~pend_clr) | sw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= INT_LINES;
      emr_q  <= '0;
      rtsr_q <= '0;
      ftsr_q <= '0;
      swt_q  <= '0;
    end else begin
      imr_q  <= imr_n;
      emr_q  <= emr_n;
      rtsr_q <= rtsr_n;
      ftsr_q <= ftsr_n;
      swt_q  <= swt_n;
    end
  end

  // Read path: widen to both banks; absent mask lines read as 1
  logic [WIDE_W-1:0] w_imr, w_emr, w_rtsr, w_ftsr, w_swt, w_pend;
  always_comb begin
    w_imr  = '1;  w_imr[N-1:0]  = imr_q;
    w_emr  = '0;  w_emr[N-1:0]  = emr_q;
    w_rtsr = '0;  w_rtsr[N-1:0] = rtsr_q;
    w_ftsr = '0;  w_ftsr[N-1:0] = ftsr_q;
    w_swt  = '0;  w_swt[N-1:0]  = swt_q;
    w_pend = '0;  w_pend[N-1:0] = pend & EXT;
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (rsel)
        RSEL_IMASK: bus_rdata = w_imr [bus_addr[5]*REG_W +: REG_W];
        RSEL_EMASK: bus_rdata = w_emr [bus_addr[5]*REG_W +: REG_W];
        RSEL_RISE:  bus_rdata = w_rtsr[bus_addr[5]*REG_W +: REG_W];
        RSEL_FALL:  bus_rdata = w_ftsr[bus_addr[5]*REG_W +: REG_W];
        RSEL_SWTRG: bus_rdata = w_swt [bus_addr[5]*REG_W +: REG_W];
        RSEL_PEND:  bus_rdata = w_pend[bus_addr[5]*REG_W +: REG_W];
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign imr  = imr_q;
  assign emr  = emr_q;
  assign rtsr = rtsr_q;
  assign ftsr = ftsr_q;
endmodule

// File: rtl/evt_lines.sv
module evt_lines #(
  parameter int unsigned  N         = 36,
  parameter logic [N-1:0] INT_LINES = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic         stop_mode,
  input  logic [N-1:0] imr,
  input  logic [N-1:0] emr,
  input  logic [N-1:0] rtsr,
  input  logic [N-1:0] ftsr,
  input  logic [N-1:0] sw_trig,
  input  logic [N-1:0] pend_clr,
  input  logic [N-1:0] trig_wr_hit,
  output logic [N-1:0] pend,
  output logic [N-1:0] irq_req,
  output logic         evt_pulse
);
  localparam logic [N-1:0] EXT = ~INT_LINES;

  logic [N-1:0] prev_q, pend_q, iirq_q;
  logic [N-1:0] pend_n, iirq_n, evt_hit, rise, fall;
  logic         evt_q, evt_n;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      if (INT_LINES[i]) begin : g_int
        assign pend_n[i]  = 1'b0;
        assign iirq_n[i]  = rise[i] & imr[i] & stop_mode;
        assign evt_hit[i] = rise[i] & emr[i] & stop_mode;
      end else begin : g_ext
        logic hw_edge, set_p;
        assign hw_edge    = (rise[i] & rtsr[i]) | (fall[i] & ftsr[i]);
        assign set_p      = ((hw_edge & ~trig_wr_hit[i]) | sw_trig[i]) & imr[i];
        assign pend_n[i]  = (pend_q[i] & ~pend_clr[i]) | set_p;
        assign iirq_n[i]  = 1'b0;
        assign evt_hit[i] = (hw_edge | sw_trig[i]) & emr[i];
      end
    end
  endgenerate

  assign evt_n = |evt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      iirq_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend_q <= pend_n;
      iirq_q <= iirq_n;
      evt_q  <= evt_n;
    end
  end

  assign pend      = pend_q;
  assign irq_req   = (pend_q & imr & EXT) | iirq_q;
  assign evt_pulse = evt_q;
endmodule

// File: rtl/line_evt_ctrl.sv
module line_evt_ctrl
  import evt_pkg::*;
#(
  parameter int unsigned  NUM_LINES   = 36,
  parameter int unsigned  SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] INT_LINES = 36'hC_1F80_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [5:0]           bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 stop_mode,
  output logic [NUM_LINES-1:0] irq_req,
  output logic                 evt_pulse,
  output logic                 wake_req
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_LINES-1:0] lvl, pend, imr_q, emr_q, rtsr_q, ftsr_q;
  logic [NUM_LINES-1:0] sw_trig, pend_clr, trig_wr_hit;

  evt_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(line_in), .dout(lvl)
  );

  evt_regs #(.N(NUM_LINES), .INT_LINES(INT_LINES)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend), .imr(imr_q), .emr(emr_q), .rtsr(rtsr_q), .ftsr(ftsr_q),
    .sw_trig(sw_trig), .pend_clr(pend_clr), .trig_wr_hit(trig_wr_hit)
  );

  evt_lines #(.N(NUM_LINES), .INT_LINES(INT_LINES)) u_lines (
    .clk(clk), .rst_n(rst_int_n), .lvl(lvl), .stop_mode(stop_mode),
    .imr(imr_q), .emr(emr_q), .rtsr(rtsr_q), .ftsr(ftsr_q),
    .sw_trig(sw_trig), .pend_clr(pend_clr), .trig_wr_hit(trig_wr_hit),
    .pend(pend), .irq_req(irq_req), .evt_pulse(evt_pulse)
  );

  assign wake_req = (|irq_req) | evt_pulse;
endmodule

// File: rtl/evt_chk.sv
module evt_chk #(
  parameter int unsigned  N         = 36,
  parameter logic [N-1:0] INT_LINES = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stop_mode,
  input logic         bus_sel,
  input logic         bus_wr,
  input logic [5:0]   bus_addr,
  input logic [31:0]  bus_rdata,
  input logic [N-1:0] irq_req,
  input logic [N-1:0] imr,
  input logic [N-1:0] pend,
  input logic [N-1:0] pend_clr
);
  p_int_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stop_mode) |-> ((irq_req & INT_LINES) == '0));

  p_ext_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~INT_LINES & ~imr) == '0));

  p_pend_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~$past(pend_clr) & ~pend) == '0));

  p_resv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[5:2] == 4'h5) |-> (bus_rdata[28:23] == 6'd0));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[4:3] == 2'b11) |-> (bus_rdata == 32'd0));
endmodule

bind line_evt_ctrl evt_chk #(.N(NUM_LINES), .INT_LINES(INT_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_req(irq_req), .imr(imr_q), .pend(pend), .pend_clr(pend_clr)
);

// File: tb/sim_line_evt_ctrl.sv
module sim_line_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [35:0] line_in, irq_req;
  logic        stop_mode, evt_pulse, wake_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic smp = 1'b0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq_req, 2 evt_pulse, 3 wake_req
    logic [35:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  line_evt_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_in(line_in), .stop_mode(stop_mode), .irq_req(irq_req),
    .evt_pulse(evt_pulse), .wake_req(wake_req)
  );

  // Monitor: pops one expected item per sampling strobe
  always @(negedge clk) begin
    item_t it;
    logic [35:0] act;
    if (smp && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = {4'd0, bus_rdata};
        1:       act = irq_req;
        2:       act = {35'd0, evt_pulse};
        default: act = {35'd0, wake_req};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic tick3();
    tick(); tick(); tick();
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = 0; it.exp = {4'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; smp = 1'b1;
    tick();
    smp = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic chk_out(input int kind, input logic [35:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    smp = 1'b1;
    tick();
    smp = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] m1;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    line_in = '0; stop_mode = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();

    // R9 reset values
    chk_rd(6'h00, 32'h1F80_0000, "R9 imask0");
    chk_rd(6'h20, 32'hFFFF_FFFC, "R9 imask1");
    chk_rd(6'h04, 32'h0, "R9 emask0");
    chk_rd(6'h14, 32'h0, "R9 pend0");
    chk_out(1, 36'h0, "R9 irq idle");
    chk_out(3, 36'h0, "R11 wake idle");

    m1 = 32'h1F80_003F;
    wr(6'h08, 32'h3);
    wr(6'h0C, 32'h2);
    wr(6'h00, m1);

    // R1 latency, R2 rising on line 0
    line_in[0] = 1'b1;
    tick(); tick();
    chk_out(1, 36'h0, "R1 not before third edge");
    chk_out(1, 36'h1, "R1 third edge");
    chk_out(3, 36'h1, "R11 wake on irq");
    chk_rd(6'h14, 32'h1, "R3 pending set");

    // R3 write 0 then write 1
    wr(6'h14, 32'h0);
    chk_rd(6'h14, 32'h1, "R3 write0 no effect");
    wr(6'h14, 32'h1);
    chk_rd(6'h14, 32'h0, "R3 cleared");
    chk_out(1, 36'h0, "R3 irq dropped");

    // R2 falling ignored on line 0; both edges on line 1
    line_in[0] = 1'b0; tick3();
    chk_rd(6'h14, 32'h0, "R2 falling unselected");
    line_in[1] = 1'b1; tick3();
    chk_rd(6'h14, 32'h2, "R2 rise of both");
    wr(6'h14, 32'h2);
    line_in[1] = 1'b0; tick3();
    chk_rd(6'h14, 32'h2, "R2 fall of both");

    // R4 masking keeps pending
    wr(6'h00, m1 & ~32'h2);
    chk_out(1, 36'h0, "R4 masked");
    chk_rd(6'h14, 32'h2, "R4 pending kept");
    wr(6'h00, m1);
    chk_out(1, 36'h2, "R4 unmasked again");
    wr(6'h14, 32'h2);

    // R3 set wins over same-cycle clear
    line_in[0] = 1'b1; tick(); tick();
    wr(6'h14, 32'h1);
    chk_rd(6'h14, 32'h1, "R3 set wins");
    wr(6'h14, 32'h1);
    line_in[0] = 1'b0; tick3();

    // R6 event only
    wr(6'h08, 32'h7);
    wr(6'h04, 32'h4);
    m1 = m1 & ~32'h4;
    wr(6'h00, m1);
    line_in[2] = 1'b1; tick3();
    chk_out(2, 36'h1, "R6 pulse");
    chk_out(2, 36'h0, "R6 one cycle");
    chk_rd(6'h14, 32'h0, "R6 no pending");

    // R8 collision with rising-select write
    line_in[0] = 1'b1; tick(); tick();
    wr(6'h08, 32'h7);
    chk_rd(6'h14, 32'h0, "R8 suppressed");
    line_in[0] = 1'b0; tick3();
    line_in[0] = 1'b1; tick3();
    chk_rd(6'h14, 32'h1, "R8 control edge");
    wr(6'h14, 32'h1);

    // R7 software trigger
    wr(6'h10, 32'h20);
    chk_rd(6'h14, 32'h20, "R7 pending by software");
    chk_rd(6'h10, 32'h20, "R7 bit set");
    wr(6'h14, 32'h20);
    chk_rd(6'h10, 32'h0, "R7 bit self clear");
    wr(6'h10, 32'h40);
    chk_rd(6'h14, 32'h0, "R7 masked no pending");

    // R5 internal lines
    line_in[23] = 1'b1; tick3();
    chk_out(1, 36'h0, "R5 running ignored");
    line_in[23] = 1'b0; tick3();
    stop_mode = 1'b1;
    line_in[23] = 1'b1; tick3();
    chk_out(1, 36'h0_0080_0000, "R5 stop rising");
    chk_out(1, 36'h0, "R5 single cycle");
    chk_rd(6'h14, 32'h0, "R5 no pending bit");
    line_in[23] = 1'b0; tick3();
    chk_out(1, 36'h0, "R5 falling ignored");
    line_in[34] = 1'b1; tick3();
    chk_out(1, 36'h4_0000_0000, "R5 bank1 line");
    stop_mode = 1'b0;

    // R10 reserved and unmapped
    wr(6'h08, 32'hFFFF_FFFF);
    chk_rd(6'h08, 32'hE07F_FFFF, "R10 rise reserved");
    wr(6'h28, 32'hFFFF_FFFF);
    chk_rd(6'h28, 32'h3, "R10 bank1 rise");
    wr(6'h18, 32'hFFFF_FFFF);
    chk_rd(6'h18, 32'h0, "R10 unmapped 0x18");
    chk_rd(6'h3C, 32'h0, "R10 unmapped 0x3C");
    chk_rd(6'h20, 32'hFFFF_FFFC, "R9 bank1 mask kept");

    tick();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule